// File: doc/BRIEF.md
# Flat Page-Table Address Translator

The block turns 32-bit device virtual addresses into physical addresses. Every page is 4 KiB, so the low 12 bits of an address pass through unchanged. The upper 20 bits index one flat table in memory that holds one 32-bit descriptor per virtual page. An 8-entry fully associative TLB holds recent translations. A request that hits is answered in the cycle it is presented. A request that misses issues one descriptor read on a simple memory port and is answered in the cycle the read data returns.

Software drives a small write-only configuration port. Through it software sets the table base, the protect address and the bounds of a range, and issues invalidation commands. An all-entry flush and a page-range flush are both available. A sticky flag reports that a range flush has finished. A descriptor without its valid bit gives a translation fault, and the access is then steered to the protect address. A table base of zero switches translation off, and every address maps to itself.

Top module: `flat_xlate`

## Requirements
- R1: For a translated response, resp_pa_o[11:0] equals req_va_i[11:0], and resp_pa_o[31:12] is the physical page number taken from the matching descriptor or TLB entry.
- R2: On a TLB miss with translation enabled, mem_req_o is high for exactly the request cycle, with mem_addr_o = table base + req_va_i[31:12] * 4. No further read is issued until that read's mem_rvalid_i.
- R3: A descriptor is valid only when bit 1 is set. Bit 3 is driven out as resp_nonsec_o, and bits 31:12 form the physical page number.
- R4: A descriptor with bit 1 clear gives resp_fault_o = 1 with resp_pa_o = protect address. The protect register (cfg address 1) keeps bits 31:7 only. A fault is never cached, so a repeat of the address walks again.
- R5: A TLB hit raises resp_valid_o in the request cycle with no memory read. A miss raises resp_valid_o in the cycle mem_rvalid_i is high.
- R6: The TLB holds 8 entries and fills them in round-robin order. A ninth distinct page replaces the oldest fill.
- R7: Writing 2 to the command register (cfg address 4) invalidates every TLB entry.
- R8: Writing 1 to the command register invalidates the entries whose page number lies between the start page (cfg address 2) and the end page (cfg address 3), both bounds included. Both bound registers keep bits 31:12 only.
- R9: inv_done_o is high from the clock edge that applies a range flush. Writing 0 to cfg address 5 clears it, and a nonzero write there leaves it unchanged. It is low after reset.
- R10: With the table base (cfg address 0) equal to zero, which is the reset value, resp_valid_o follows req_valid_i in the same cycle with resp_pa_o = req_va_i, and no memory read is made.
- R11: A flush command written while a descriptor read is outstanding takes effect in the cycle that read returns. The returned translation is delivered but not cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request, held until the response |
| req_va_i | input | 32 | Virtual address, held with the request |
| resp_valid_o | output | 1 | Response strobe |
| resp_pa_o | output | 32 | Physical address, or protect address on fault |
| resp_fault_o | output | 1 | Translation fault |
| resp_nonsec_o | output | 1 | Non-secure attribute of the page |
| mem_req_o | output | 1 | Descriptor read request, one cycle |
| mem_addr_o | output | 32 | Descriptor byte address |
| mem_rvalid_i | input | 1 | Descriptor read data valid |
| mem_rdata_i | input | 32 | Descriptor read data |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register select |
| cfg_wdata_i | input | 32 | Configuration write data |
| inv_done_o | output | 1 | Range flush complete flag |

## Verification
The checker assumes the requester holds req_valid_i and req_va_i steady until resp_valid_o. It also assumes mem_rvalid_i pulses once per read, and never in the cycle of the read or while no read is outstanding. The bench honours both. Its memory responder answers every read after a fixed three-cycle latency, and each request task drops the request only after a response is predicted. The bench writes the table base and the range bounds only while no read is pending. Flush commands are also sent in the middle of a walk.

// File: rtl/flat_xlate_pkg.sv
package flat_xlate_pkg;
  typedef enum logic [2:0] {
    CFG_BASE = 3'd0,
    CFG_PROT = 3'd1,
    CFG_RLO  = 3'd2,
    CFG_RHI  = 3'd3,
    CFG_CMD  = 3'd4,
    CFG_DONE = 3'd5
  } cfg_sel_e;

  localparam logic [31:0] CMD_FLUSH_RNG = 32'h1;
  localparam logic [31:0] CMD_FLUSH_ALL = 32'h2;
  localparam int DESC_VLD_BIT = 1;
  localparam int DESC_NS_BIT  = 3;
  localparam int PROT_ALIGN_BITS = 7;

  typedef enum logic {WALK_IDLE, WALK_WAIT} walk_state_e;
endpackage

// File: rtl/flat_xlate_regs.sv
module flat_xlate_regs
  import flat_xlate_pkg::*;
#(
  parameter int AW = 32,
  parameter int PB = 12,
  localparam int VPN_W = AW - PB
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_addr_i,
  input  logic [AW-1:0]    cfg_wdata_i,
  input  logic             apply_ok_i,
  output logic [AW-1:0]    base_o,
  output logic [AW-1:0]    protect_o,
  output logic [VPN_W-1:0] rng_lo_o,
  output logic [VPN_W-1:0] rng_hi_o,
  output logic             flush_all_o,
  output logic             flush_rng_o,
  output logic             inv_busy_o,
  output logic             done_o
);
  logic [AW-1:0] base_q;
  logic [AW-1:PROT_ALIGN_BITS] prot_q;
  logic [VPN_W-1:0] lo_q, hi_q;
  logic pend_all_q, pend_rng_q, done_q;
  logic cmd_wr, want_all, want_rng;

  assign cmd_wr   = cfg_we_i && (cfg_addr_i == CFG_CMD);
  assign want_all = pend_all_q || (cmd_wr && cfg_wdata_i == CMD_FLUSH_ALL);
  assign want_rng = pend_rng_q || (cmd_wr && cfg_wdata_i == CMD_FLUSH_RNG);

  // a command arriving mid-walk is held until the walk returns
  assign flush_all_o = want_all && apply_ok_i;
  assign flush_rng_o = want_rng && apply_ok_i;
  assign inv_busy_o  = want_all || want_rng;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q     <= '0;
      prot_q     <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
      pend_all_q <= 1'b0;
      pend_rng_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      pend_all_q <= want_all && !apply_ok_i;
      pend_rng_q <= want_rng && !apply_ok_i;
      if (flush_rng_o) done_q <= 1'b1;
      else if (cfg_we_i && cfg_addr_i == CFG_DONE && cfg_wdata_i == '0) done_q <= 1'b0;
      if (cfg_we_i) begin
        unique case (cfg_addr_i)
          CFG_BASE: base_q <= cfg_wdata_i;
          CFG_PROT: prot_q <= cfg_wdata_i[AW-1:PROT_ALIGN_BITS];
          CFG_RLO:  lo_q   <= cfg_wdata_i[AW-1:PB];
          CFG_RHI:  hi_q   <= cfg_wdata_i[AW-1:PB];
          default: ;
        endcase
      end
    end
  end

  assign base_o    = base_q;
  assign protect_o = {prot_q, {PROT_ALIGN_BITS{1'b0}}};
  assign rng_lo_o  = lo_q;
  assign rng_hi_o  = hi_q;
  assign done_o    = done_q;
endmodule

// File: rtl/flat_xlate_tlb.sv
module flat_xlate_tlb #(
  parameter int N = 8,
  parameter int VPN_W = 20,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             hit_o,
  output logic [VPN_W-1:0] hit_ppn_o,
  output logic             hit_ns_o,
  input  logic             fill_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [VPN_W-1:0] fill_ppn_i,
  input  logic             fill_ns_i,
  input  logic             flush_all_i,
  input  logic             flush_rng_i,
  input  logic [VPN_W-1:0] rng_lo_i,
  input  logic [VPN_W-1:0] rng_hi_i
);
  typedef struct packed {
    logic             vld;
    logic             ns;
    logic [VPN_W-1:0] vpn;
    logic [VPN_W-1:0] ppn;
  } ent_t;

  logic [N-1:0]     match;
  logic [N-1:0]     ns_v;
  logic [VPN_W-1:0] ppn_a [N];
  logic [IDXW-1:0]  rr_q;

  for (genvar g = 0; g < N; g++) begin : g_ent
    ent_t ent_q;
    logic in_rng;
    assign in_rng = (ent_q.vpn >= rng_lo_i) && (ent_q.vpn <= rng_hi_i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q <= '0;
      else if (flush_all_i || (flush_rng_i && in_rng)) ent_q.vld <= 1'b0;
      else if (fill_i && rr_q == IDXW'(g)) ent_q <= '{1'b1, fill_ns_i, fill_vpn_i, fill_ppn_i};
    end
    assign match[g] = ent_q.vld && (ent_q.vpn == lk_vpn_i);
    assign ns_v[g]  = ent_q.ns;
    assign ppn_a[g] = ent_q.ppn;
  end

  always_comb begin
    hit_ppn_o = '0;
    hit_ns_o  = 1'b0;
    for (int i = 0; i < N; i++) begin
      hit_ppn_o = hit_ppn_o | ({VPN_W{match[i]}} & ppn_a[i]);
      hit_ns_o  = hit_ns_o | (match[i] & ns_v[i]);
    end
  end
  assign hit_o = |match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (fill_i) rr_q <= (rr_q == IDXW'(N - 1)) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/flat_xlate_walk.sv
module flat_xlate_walk
  import flat_xlate_pkg::*;
#(
  parameter int AW = 32,
  parameter int PB = 12,
  localparam int VPN_W = AW - PB,
  localparam int PADW = AW - VPN_W - 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             xlate_en_i,
  input  logic             hit_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [AW-1:0]    base_i,
  input  logic             mem_rvalid_i,
  output logic             busy_o,
  output logic             ret_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o
);
  walk_state_e st_q;

  assign busy_o     = (st_q == WALK_WAIT);
  assign ret_o      = busy_o && mem_rvalid_i;
  assign mem_req_o  = (st_q == WALK_IDLE) && req_valid_i && xlate_en_i && !hit_i;
  assign mem_addr_o = base_i + {{PADW{1'b0}}, vpn_i, 2'b00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= WALK_IDLE;
    else if (mem_req_o) st_q <= WALK_WAIT;
    else if (ret_o) st_q <= WALK_IDLE;
  end
endmodule

// File: rtl/flat_xlate.sv
module flat_xlate
  import flat_xlate_pkg::*;
#(
  parameter int AW = 32,
  parameter int PB = 12,
  parameter int TLB_N = 8,
  localparam int VPN_W = AW - PB
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_va_i,
  output logic          resp_valid_o,
  output logic [AW-1:0] resp_pa_o,
  output logic          resp_fault_o,
  output logic          resp_nonsec_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [AW-1:0] mem_rdata_i,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_addr_i,
  input  logic [AW-1:0] cfg_wdata_i,
  output logic          inv_done_o
);
  logic [AW-1:0]    tbl_base, protect;
  logic [VPN_W-1:0] rng_lo, rng_hi, hit_ppn, va_vpn;
  logic flush_all, flush_rng, inv_busy, hit, hit_ns;
  logic walk_busy, walk_ret, xlate_en, fill, desc_ok;

  assign va_vpn   = req_va_i[AW-1:PB];
  assign xlate_en = (tbl_base != '0);
  assign desc_ok  = mem_rdata_i[DESC_VLD_BIT];
  assign fill     = walk_ret && desc_ok && !inv_busy;

  flat_xlate_regs #(.AW(AW), .PB(PB)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .apply_ok_i(!walk_busy || mem_rvalid_i),
    .base_o(tbl_base), .protect_o(protect), .rng_lo_o(rng_lo), .rng_hi_o(rng_hi),
    .flush_all_o(flush_all), .flush_rng_o(flush_rng), .inv_busy_o(inv_busy),
    .done_o(inv_done_o)
  );

  flat_xlate_tlb #(.N(TLB_N), .VPN_W(VPN_W)) u_tlb (
    .clk_i, .rst_ni, .lk_vpn_i(va_vpn), .hit_o(hit), .hit_ppn_o(hit_ppn),
    .hit_ns_o(hit_ns), .fill_i(fill), .fill_vpn_i(va_vpn),
    .fill_ppn_i(mem_rdata_i[AW-1:PB]), .fill_ns_i(mem_rdata_i[DESC_NS_BIT]),
    .flush_all_i(flush_all), .flush_rng_i(flush_rng),
    .rng_lo_i(rng_lo), .rng_hi_i(rng_hi)
  );

  flat_xlate_walk #(.AW(AW), .PB(PB)) u_walk (
    .clk_i, .rst_ni, .req_valid_i, .xlate_en_i(xlate_en), .hit_i(hit),
    .vpn_i(va_vpn), .base_i(tbl_base), .mem_rvalid_i,
    .busy_o(walk_busy), .ret_o(walk_ret), .mem_req_o, .mem_addr_o
  );

  always_comb begin
    resp_valid_o  = 1'b0;
    resp_pa_o     = req_va_i;
    resp_fault_o  = 1'b0;
    resp_nonsec_o = 1'b0;
    if (!xlate_en) begin
      resp_valid_o = req_valid_i;
    end else if (walk_ret) begin
      resp_valid_o = 1'b1;
      if (desc_ok) begin
        resp_pa_o     = {mem_rdata_i[AW-1:PB], req_va_i[PB-1:0]};
        resp_nonsec_o = mem_rdata_i[DESC_NS_BIT];
      end else begin
        resp_pa_o    = protect;
        resp_fault_o = 1'b1;
      end
    end else if (!walk_busy && req_valid_i && hit) begin
      resp_valid_o  = 1'b1;
      resp_pa_o     = {hit_ppn, req_va_i[PB-1:0]};
      resp_nonsec_o = hit_ns;
    end
  end
endmodule

// File: rtl/flat_xlate_chk.sv
module flat_xlate_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [AW-1:0] req_va_i,
  input logic          resp_valid_o,
  input logic [AW-1:0] resp_pa_o,
  input logic          resp_fault_o,
  input logic          mem_req_o,
  input logic          mem_rvalid_i,
  input logic [AW-1:0] tbl_base
);
  p_offset_kept_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && !resp_fault_o |-> resp_pa_o[11:0] == req_va_i[11:0]);

  p_single_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  p_fault_aligned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && resp_fault_o |-> resp_pa_o[6:0] == 7'd0);

  p_miss_no_resp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !resp_valid_o);

  p_resp_has_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> req_valid_i);

  p_bypass_identity_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_base == '0) && req_valid_i |-> resp_valid_o && resp_pa_o == req_va_i && !mem_req_o);
endmodule

bind flat_xlate flat_xlate_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_va_i(req_va_i),
  .resp_valid_o(resp_valid_o), .resp_pa_o(resp_pa_o), .resp_fault_o(resp_fault_o),
  .mem_req_o(mem_req_o), .mem_rvalid_i(mem_rvalid_i), .tbl_base(tbl_base)
);

// File: tb/flat_xlate_bench.sv
module flat_xlate_bench;
  localparam int LAT = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_va_i = '0;
  logic        resp_valid_o, resp_fault_o, resp_nonsec_o, mem_req_o, inv_done_o;
  logic [31:0] resp_pa_o, mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;

  always #2 clk_i = ~clk_i;

  flat_xlate u_flat_xlate (
    .clk_i, .rst_ni, .req_valid_i, .req_va_i, .resp_valid_o, .resp_pa_o,
    .resp_fault_o, .resp_nonsec_o, .mem_req_o, .mem_addr_o, .mem_rvalid_i,
    .mem_rdata_i, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .inv_done_o
  );

  int compared = 0, mismatched = 0;
  string tag = "R10";

  // reference state
  logic [31:0] m_base = '0, m_prot = '0, mem_desc = '0;
  logic [19:0] m_lo = '0, m_hi = '0;
  bit p_all = 0, p_rng = 0, m_done = 0, m_wait = 0, last_valid = 0;
  int mem_cnt = 0, rr = 0;
  bit          s_v [8];
  bit          s_ns [8];
  logic [19:0] s_vpn [8];
  logic [19:0] s_ppn [8];
  logic [31:0] pt [int unsigned];

  task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic cyc();
    bit rv = 0, ev = 0, ef = 0, ens = 0, emr = 0;
    bit cmd_all, cmd_rng, want_all, want_rng, ok;
    logic [31:0] epa = '0, ema = '0;
    logic [19:0] vpn;
    int hidx = -1;
    if (mem_cnt != 0) begin
      mem_cnt--;
      if (mem_cnt == 0) rv = 1;
    end
    mem_rvalid_i = rv;
    mem_rdata_i  = rv ? mem_desc : '0;
    #1;
    vpn = req_va_i[31:12];
    for (int i = 0; i < 8; i++) if (s_v[i] && s_vpn[i] == vpn) hidx = i;
    if (m_base == 0) begin
      ev = req_valid_i; epa = req_va_i;
    end else if (!m_wait) begin
      if (req_valid_i && hidx >= 0) begin
        ev = 1; epa = {s_ppn[hidx], req_va_i[11:0]}; ens = s_ns[hidx];
      end else if (req_valid_i) begin
        emr = 1; ema = m_base + {10'd0, vpn, 2'b00};
      end
    end else if (rv) begin
      ev = 1;
      if (mem_desc[1]) begin
        epa = {mem_desc[31:12], req_va_i[11:0]}; ens = mem_desc[3];
      end else begin
        epa = m_prot; ef = 1;
      end
    end
    chk("resp_valid", {31'd0, resp_valid_o}, {31'd0, ev});
    if (ev) begin
      chk("resp_pa", resp_pa_o, epa);
      chk("resp_fault", {31'd0, resp_fault_o}, {31'd0, ef});
      chk("resp_nonsec", {31'd0, resp_nonsec_o}, {31'd0, ens});
    end
    chk("mem_req", {31'd0, mem_req_o}, {31'd0, emr});
    if (emr) chk("mem_addr", mem_addr_o, ema);
    chk("inv_done", {31'd0, inv_done_o}, {31'd0, m_done});
    last_valid = ev;

    // state for the coming edge
    cmd_all  = cfg_we_i && cfg_addr_i == 3'd4 && cfg_wdata_i == 32'h2;
    cmd_rng  = cfg_we_i && cfg_addr_i == 3'd4 && cfg_wdata_i == 32'h1;
    want_all = cmd_all || p_all;
    want_rng = cmd_rng || p_rng;
    ok       = !m_wait || rv;
    if (m_wait && rv && mem_desc[1] && !(want_all || want_rng)) begin
      s_v[rr] = 1; s_vpn[rr] = vpn; s_ppn[rr] = mem_desc[31:12]; s_ns[rr] = mem_desc[3];
      rr = (rr + 1) % 8;
    end
    if (want_all && ok) for (int i = 0; i < 8; i++) s_v[i] = 0;
    if (want_rng && ok) begin
      for (int i = 0; i < 8; i++) if (s_vpn[i] >= m_lo && s_vpn[i] <= m_hi) s_v[i] = 0;
      m_done = 1;
    end else if (cfg_we_i && cfg_addr_i == 3'd5 && cfg_wdata_i == 0) m_done = 0;
    p_all = want_all && !ok;
    p_rng = want_rng && !ok;
    if (m_wait && rv) m_wait = 0;
    else if (emr) begin
      m_wait = 1; mem_cnt = LAT;
      mem_desc = pt.exists(int'(vpn)) ? pt[int'(vpn)] : '0;
    end
    if (cfg_we_i) begin
      case (cfg_addr_i)
        3'd0: m_base = cfg_wdata_i;
        3'd1: m_prot = cfg_wdata_i & 32'hFFFF_FF80;
        3'd2: m_lo   = cfg_wdata_i[31:12];
        3'd3: m_hi   = cfg_wdata_i[31:12];
        default: ;
      endcase
    end
    @(negedge clk_i);
  endtask

  task automatic cfg_wr(logic [2:0] a, logic [31:0] d);
    cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
    cyc();
    cfg_we_i = 0;
  endtask

  // request with an optional config write k cycles into it
  task automatic xlate(logic [31:0] va, int k = -1, logic [2:0] a = 3'd0, logic [31:0] d = 0);
    int n = 0;
    req_valid_i = 1; req_va_i = va;
    do begin
      if (n == k) begin cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d; end
      cyc();
      cfg_we_i = 0;
      n++;
    end while (!last_valid);
    req_valid_i = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    mismatched++;
    $display("FAIL R5 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) begin s_v[i] = 0; s_ns[i] = 0; s_vpn[i] = '0; s_ppn[i] = '0; end
    for (int i = 0; i < 16; i++)
      pt[32'h100 + i] = ((32'h5000 + i) << 12) | 32'h2 | ((i % 2 == 1) ? 32'h8 : 32'h0);
    pt[32'h300] = 32'h0007_7008;            // valid bit clear
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    tag = "R9"; idle(2);                     // reset state: done low
    tag = "R10"; xlate(32'h1234_5678); xlate(32'hFFFF_F001);
    cfg_wr(3'd1, 32'h8000_00FF);
    cfg_wr(3'd0, 32'h0040_0000);
    tag = "R2"; xlate(32'h0010_0ABC);
    tag = "R5"; xlate(32'h0010_0123);
    tag = "R3"; xlate(32'h0010_1FFF); xlate(32'h0010_1000);
    tag = "R1"; xlate(32'h0010_2ABC);
    tag = "R4"; xlate(32'h0020_0040); xlate(32'h0020_0040); xlate(32'h0030_0010);
    tag = "R7"; cfg_wr(3'd4, 32'h2); xlate(32'h0010_0ABC);
    tag = "R6";
    for (int i = 1; i <= 8; i++) xlate(32'h0010_0000 + (i << 12));
    xlate(32'h0010_0004); xlate(32'h0010_8004); xlate(32'h0010_1004);
    tag = "R8";
    cfg_wr(3'd2, 32'h0010_3123); cfg_wr(3'd3, 32'h0010_5FFF);
    cfg_wr(3'd4, 32'h1); idle(1);
    xlate(32'h0010_2000); xlate(32'h0010_3000); xlate(32'h0010_5000); xlate(32'h0010_6000);
    tag = "R9"; cfg_wr(3'd5, 32'h5); idle(1); cfg_wr(3'd5, 32'h0); idle(1);
    tag = "R11";
    xlate(32'h0010_9000, 1, 3'd4, 32'h2); xlate(32'h0010_9000);
    cfg_wr(3'd2, 32'h0010_A000); cfg_wr(3'd3, 32'h0010_A000);
    xlate(32'h0010_A000, 2, 3'd4, 32'h1); idle(1); xlate(32'h0010_A000);
    xlate(32'h0010_9000);
    tag = "R10"; cfg_wr(3'd0, 32'h0); xlate(32'h0010_9000);
    idle(2);
    finish_run();
  end
endmodule